// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate

This datapath serves a processor execute stage for the family of dual 16x16 signed multiply operations. Each 32-bit operand is split into two signed halfwords. The low half of the first operand is multiplied by the low half of the second operand, and the high half by the high half. The two products are then added, or the second is subtracted from the first. An optional 32-bit accumulator is added to that result. The result is the low 32 bits, which wrap with no saturation.

Alongside the result, the block updates a sticky overflow bit inside a status word that passes through it. Two addition points can raise the bit. The first is the sum of the two products, which is checked only in the adding forms. The second is the final accumulate, which is checked only when an accumulator is used. The bit is only ever set and never cleared, and every other status bit passes through unchanged.

The caller supplies decoded fields and register values. A valid strobe travels with the data. A parameter selects either a single register stage or a purely combinational path.

Top module: `dual_half_mac`

## Requirements
- R1: After reset, with the registered variant (PIPE=1), `out_valid` is 0, `result` is 0 and `stat_out` is 0.
- R2: With PIPE=1, `out_valid` is asserted exactly one clock after a cycle in which `in_valid` is high, and is low after a cycle in which `in_valid` is low.
- R3: Each halfword is signed. Product one is `opa[15:0]*opb[15:0]` and product two is `opa[31:16]*opb[31:16]`. When `op_f[1]`=0, `result` is product one plus product two.
- R4: When `op_f[0]`=1, the two halves of `opb` are exchanged before multiplying.
- R5: When `op_f[1]`=1, the product combination is product one minus product two.
- R6: When `acc_sel` is not 15, `acc` is added to the product combination.
- R7: When `acc_sel` equals 15, `acc` has no effect on `result` or `stat_out`.
- R8: In the adding forms (`op_f[1]`=0), bit 27 of `stat_out` is set if product one plus product two overflows as a signed 32-bit addition. Overflow here means that both addends have the same sign and the sum's sign differs from theirs.
- R9: With accumulation enabled, bit 27 of `stat_out` is set if the product combination plus `acc` overflows as a signed addition. This applies in both the adding and the subtracting forms.
- R10: In the subtracting forms, the subtraction itself never sets bit 27. For example, `opa=opb=0x80008000` with `op_f[1]`=1 and no accumulate leaves bit 27 clear.
- R11: `stat_out` equals `stat_in` with bit 27 ORed in. The bit is never cleared, and all other bits pass through.
- R12: `result` is the low 32 bits of the full computation and wraps modulo 2^32. For example, `0x40000000+0x40000000` gives `0x80000000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| opa | input | 32 | First operand (two signed halfwords) |
| opb | input | 32 | Second operand (two signed halfwords) |
| acc | input | 32 | Accumulator value |
| op_f | input | 3 | Operation field: bit 0 swaps the halves of opb, bit 1 selects subtract |
| acc_sel | input | 4 | Accumulator register index; 15 means no accumulate |
| stat_in | input | 32 | Incoming status word |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Wrapped 32-bit result |
| stat_out | output | 32 | Status word with the sticky overflow bit 27 ORed in |

## Verification
The product-sum overflow is the case that is hardest to reach from the ports. Only one input pattern produces it: both halfword pairs must be -32768 times -32768, so that each product is exactly 2^30. The stimulus applies that pattern in the adding form to raise the bit. It then applies the same pattern in the subtracting form, where the bit must stay clear. The accumulate overflow is reached separately in both directions, using an accumulator at each extreme of the signed range. One case overflows both addition points together, which checks that both the wrap and the flag hold at once.

// File: rtl/dual_half_mac.sv
module dual_half_mac #(
  parameter int W    = 32,
  parameter int SW   = 32,
  parameter int QBIT = 27,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  acc,
  input  logic [2:0]    op_f,
  input  logic [3:0]    acc_sel,
  input  logic [SW-1:0] stat_in,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic [SW-1:0] stat_out
);
  localparam int H = W / 2;

  logic [W-1:0]        b_sw;
  logic signed [W-1:0] prod_lo, prod_hi;
  logic [W-1:0]        mix, total;
  logic                use_acc, ovf_mix, ovf_acc;
  logic [W-1:0]        res_c;
  logic [SW-1:0]       stat_c;

  assign b_sw    = op_f[0] ? {opb[H-1:0], opb[W-1:H]} : opb;
  assign prod_lo = $signed(opa[H-1:0]) * $signed(b_sw[H-1:0]);
  assign prod_hi = $signed(opa[W-1:H]) * $signed(b_sw[W-1:H]);
  assign mix     = op_f[1] ? prod_lo - prod_hi : prod_lo + prod_hi;
  assign use_acc = (acc_sel != 4'hF);
  assign total   = mix + acc;

  assign ovf_mix = !op_f[1] && (prod_lo[W-1] == prod_hi[W-1]) && (mix[W-1] != prod_lo[W-1]);
  assign ovf_acc = use_acc && (mix[W-1] == acc[W-1]) && (total[W-1] != mix[W-1]);

  assign res_c  = use_acc ? total : mix;
  assign stat_c = stat_in | (SW'(ovf_mix | ovf_acc) << QBIT);

  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
          stat_out  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result   <= res_c;
            stat_out <= stat_c;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_c;
      assign stat_out  = stat_c;
    end
  endgenerate
endmodule

// File: rtl/dual_half_mac_chk.sv
module dual_half_mac_chk #(
  parameter int W    = 32,
  parameter int SW   = 32,
  parameter int QBIT = 27,
  parameter bit PIPE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb,
  input logic [W-1:0]  acc,
  input logic [2:0]    op_f,
  input logic [3:0]    acc_sel,
  input logic [SW-1:0] stat_in,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic [SW-1:0] stat_out
);
  localparam logic [SW-1:0] QMASK = SW'(1) << QBIT;

  generate
    if (PIPE) begin : g_seq
      p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stat_in[QBIT]) |=> stat_out[QBIT]);
      p_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((stat_out & ~QMASK) == ($past(stat_in) & ~QMASK)));
      p_sub_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_f[1] && acc_sel == 4'hF && !stat_in[QBIT]) |=> !stat_out[QBIT]);
      p_zero_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opa == '0 && acc_sel == 4'hF) |=> (result == '0));
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    end else begin : g_cmb
      always_comb begin
        if (rst_n && in_valid) begin
          a_sticky_r11: assert ((stat_out & stat_in) == stat_in);
          a_valid_r2: assert (out_valid);
        end
      end
    end
  endgenerate
endmodule

bind dual_half_mac dual_half_mac_chk #(.W(W), .SW(SW), .QBIT(QBIT), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb), .acc(acc),
  .op_f(op_f), .acc_sel(acc_sel), .stat_in(stat_in), .out_valid(out_valid),
  .result(result), .stat_out(stat_out)
);

// File: tb/dual_half_mac_test.sv
module dual_half_mac_test;
  localparam int PERIOD = 10;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0, acc = '0, stat_in = '0;
  logic [2:0]  op_f = '0;
  logic [3:0]  acc_sel = 4'hF;
  logic        out_valid;
  logic [31:0] result, stat_out;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_half_mac uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb), .acc(acc),
    .op_f(op_f), .acc_sel(acc_sel), .stat_in(stat_in), .out_valid(out_valid),
    .result(result), .stat_out(stat_out)
  );

  localparam logic [31:0] VA [N] = '{32'h0003_0002, 32'h0003_0002, 32'h0003_0002, 32'h0003_0002,
                                     32'hFFFF_FFFE, 32'h8000_8000, 32'h8000_8000, 32'h0000_4000,
                                     32'h0003_0002, 32'h0001_0001, 32'h0003_0002, 32'h8000_8000};
  localparam logic [31:0] VB [N] = '{32'h0005_0004, 32'h0005_0004, 32'h0005_0004, 32'h0005_0004,
                                     32'h0003_0007, 32'h8000_8000, 32'h8000_8000, 32'h0000_4000,
                                     32'h0005_0004, 32'hFFFF_FFFF, 32'h0005_0004, 32'h8000_8000};
  localparam logic [31:0] VC [N] = '{32'h0, 32'h0, 32'h0, 32'h64,
                                     32'h0, 32'h0, 32'h0, 32'h7FFF_FFFF,
                                     32'h0, 32'h8000_0000, 32'h1234_5678, 32'h8000_0000};
  localparam logic [2:0]  VO [N] = '{3'd0, 3'd1, 3'd2, 3'd0, 3'd0, 3'd0, 3'd2, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0};
  localparam logic [3:0]  VS [N] = '{4'hF, 4'hF, 4'hF, 4'h3, 4'hF, 4'hF, 4'hF, 4'h2, 4'hF, 4'h0, 4'hF, 4'h1};
  localparam logic [31:0] VI [N] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                     32'h0800_0001, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] ER [N] = '{32'h17, 32'h16, 32'hFFFF_FFF9, 32'h7B,
                                     32'hFFFF_FFEF, 32'h8000_0000, 32'h0, 32'h8FFF_FFFF,
                                     32'h17, 32'h7FFF_FFFE, 32'h17, 32'h0};
  localparam logic [31:0] ES [N] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0800_0000, 32'h0, 32'h0800_0000,
                                     32'h0800_0001, 32'h0800_0000, 32'h0, 32'h0800_0000};
  localparam string TAG [N] = '{"R3", "R4", "R5", "R6", "R3", "R8", "R10", "R9", "R11", "R9", "R7", "R12"};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'b0, out_valid}, 32'h0);
    check("R1", result, 32'h0);
    check("R1", stat_out, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      opa = VA[i]; opb = VB[i]; acc = VC[i]; op_f = VO[i]; acc_sel = VS[i]; stat_in = VI[i];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", {31'b0, out_valid}, 32'h1);
      check(TAG[i], result, ER[i]);
      check(TAG[i], stat_out, ES[i]);
    end

    @(negedge clk);
    check("R2", {31'b0, out_valid}, 32'h0);

    // R8: the adding form overflows with no accumulator
    opa = 32'h8000_8000; opb = 32'h8000_8000; op_f = 3'd1; acc_sel = 4'hF; stat_in = 32'h0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", stat_out, 32'h0800_0000);
    check("R12", result, 32'h8000_0000);

    // R7: acc_sel of 15 leaves a large accumulator without effect on the flag
    opa = 32'h0000_0001; opb = 32'h0000_0001; op_f = 3'd0; acc = 32'h7FFF_FFFF; acc_sel = 4'hF;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", result, 32'h1);
    check("R7", stat_out, 32'h0);
    finish_run();
  end
endmodule